// File: doc/BRIEF.md
# Power-Management Capability Register Block

This block gives a peripheral function a small memory-mapped power-management capability. Software sees two 32-bit words. The first is a fixed header that identifies the capability and ends the capability chain. The second is a control/status word with four parts:

- a two-bit power-state field that only takes the full-on (D0) and deep-sleep (D3hot) codes;
- a wake-event enable bit;
- a sticky wake-event status flag, cleared by writing one to it;
- a constant flag saying that leaving D3hot does not reset the function.

Hardware has three signals into and out of the gating logic. A wake-event input sets the status flag. An interrupt request from the function goes through a gate that holds it low while the function sits in D3hot. A wake-request output is raised while both the status flag and the enable bit are set. Register access uses a plain bus: address, write data, write strobe, byte-lane enables, read strobe, and registered read data with a valid flag.

Top module: `pm_cap_regs`

## Requirements
- R1: After reset the control/status word (byte address 04h) reads 00000008h and `pme_wake` is 0.
- R2: The header word (byte address 00h) always reads 00000001h: bits 7:0 are the capability ID 01h, bits 15:8 are the next pointer 00h, and writes to it have no effect.
- R3: Control/status bits 1:0 hold the power state, with 00 = D0 and 11 = D3hot. A write of 00 or 11 loads the field. A write of 01 or 10 completes, but the field keeps its old value.
- R4: Control/status bit 15 (wake status) sets in the cycle after `pme_event` is high, whether or not the enable bit is set. It stays set until software clears it.
- R5: Writing 1 to bit 15 clears the wake status, and writing 0 leaves it unchanged. If `pme_event` is high in the same cycle as a clearing write, the flag stays set.
- R6: Control/status bit 8 (wake enable) is a plain read/write bit.
- R7: While the power state is D3hot, `irq_out` is 0. Otherwise `irq_out` follows `irq_in`.
- R8: Control/status bit 3 always reads 1. Bits 31:16, 14:9, 7:4 and 2 always read 0, and writes to them have no effect.
- R9: `pme_wake` is 1 exactly when the wake status and the wake enable are both 1.
- R10: A move from D3hot to D0 leaves the wake enable and the wake status as they were. Only reset restores default values.
- R11: A read returns `bus_rdata` with `bus_rvalid` high in the cycle after `bus_re`, showing the register contents from before any write in the same cycle. Addresses other than 00h and 04h read as 0.
- R12: Byte lane 0 (`bus_be[0]`) gates writes to the power state. Byte lane 1 (`bus_be[1]`) gates writes to the wake enable and the status clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_re |
| pme_event | input | 1 | Wake event from the function |
| irq_in | input | 1 | Interrupt request from the function |
| irq_out | output | 1 | Interrupt request after power-state gating |
| pme_wake | output | 1 | Wake request (status and enable both set) |

## Verification
The bench writes the unsupported power-state codes 01 and 10 to both D0 and D3hot. A design that stored them would read back a reserved state and stop gating interrupts correctly. It raises a wake event in the same cycle as a clearing write; a design that let the clear win would lose the event and drop `pme_wake`. It masks byte lanes and writes ones to every reserved bit, which exposes lane decoding errors and reserved bits that can be written. It also goes into and out of D3hot with the enable and status set. A design that reset context on wake would come back with them cleared, and a broken gate would let `irq_out` through in D3hot.

// File: rtl/pmcap_pkg.sv
package pmcap_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    PS_D0   = 2'b00,
    PS_RSV1 = 2'b01,
    PS_RSV2 = 2'b10,
    PS_D3H  = 2'b11
  } pstate_e;

  localparam int unsigned BIT_PS_LO   = 0;
  localparam int unsigned BIT_NOSRST  = 3;
  localparam int unsigned BIT_WAKE_EN = 8;
  localparam int unsigned BIT_WAKE_ST = 15;

  localparam logic [7:0] CAP_ID_PM  = 8'h01;
  localparam logic [7:0] CAP_NEXT   = 8'h00;

  typedef struct packed {
    pstate_e ps;
    logic    wake_en;
    logic    wake_st;
  } csr_t;

  function automatic logic ps_legal(input logic [1:0] code);
    return (code == PS_D0) || (code == PS_D3H);
  endfunction

  function automatic logic [DATA_W-1:0] pack_csr(input csr_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[BIT_PS_LO +: 2]  = c.ps;
    w[BIT_NOSRST]      = 1'b1;
    w[BIT_WAKE_EN]     = c.wake_en;
    w[BIT_WAKE_ST]     = c.wake_st;
    return w;
  endfunction

endpackage

// File: rtl/pmcap_rst_sync.sv
module pmcap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pmcap_csr.sv
module pmcap_csr
  import pmcap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pme_event,
  output csr_t              csr
);

  logic [LANES-1:0] lane_wr;
  csr_t csr_q;
  csr_t csr_d;

  genvar gi;
  generate
    for (gi = 0; gi < LANES; gi++) begin : g_lane
      assign lane_wr[gi] = wr_sel & be[gi];
    end
  endgenerate

  always_comb begin
    csr_d = csr_q;
    // power state: lane 0, only the two supported codes are taken
    if (lane_wr[BIT_PS_LO / 8] && ps_legal(wdata[BIT_PS_LO +: 2])) begin
      csr_d.ps = pstate_e'(wdata[BIT_PS_LO +: 2]);
    end
    // wake enable: lane 1, plain read/write
    if (lane_wr[BIT_WAKE_EN / 8]) begin
      csr_d.wake_en = wdata[BIT_WAKE_EN];
    end
    // wake status: hardware set has priority over software clear
    if (pme_event) begin
      csr_d.wake_st = 1'b1;
    end else if (lane_wr[BIT_WAKE_ST / 8] && wdata[BIT_WAKE_ST]) begin
      csr_d.wake_st = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q.ps      <= PS_D0;
      csr_q.wake_en <= 1'b0;
      csr_q.wake_st <= 1'b0;
    end else begin
      csr_q <= csr_d;
    end
  end

  assign csr = csr_q;

endmodule

// File: rtl/pmcap_rdpath.sv
module pmcap_rdpath
  import pmcap_pkg::*;
#(
  parameter int unsigned       AW      = 8,
  parameter logic [AW-1:0]     HDR_OFS = '0,
  parameter logic [AW-1:0]     CSR_OFS = AW'(4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              re,
  input  logic [AW-1:0]     addr,
  input  csr_t              csr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  localparam logic [DATA_W-1:0] HDR_WORD =
    {{(DATA_W-16){1'b0}}, CAP_NEXT, CAP_ID_PM};

  logic [DATA_W-1:0] rdata_q, rdata_d, mux_word;
  logic              rvalid_q, rvalid_d;

  always_comb begin
    if (addr == HDR_OFS)      mux_word = HDR_WORD;
    else if (addr == CSR_OFS) mux_word = pack_csr(csr);
    else                      mux_word = '0;
  end

  always_comb begin
    rvalid_d = re;
    rdata_d  = re ? mux_word : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rvalid_d;
      if (re) rdata_q <= rdata_d;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

endmodule

// File: rtl/pmcap_gate.sv
module pmcap_gate
  import pmcap_pkg::*;
(
  input  csr_t csr,
  input  logic irq_in,
  output logic irq_out,
  output logic pme_wake
);

  logic asleep;

  always_comb begin
    asleep   = (csr.ps == PS_D3H);
    irq_out  = irq_in & ~asleep;
    pme_wake = csr.wake_st & csr.wake_en;
  end

endmodule

// File: rtl/pm_cap_regs.sv
module pm_cap_regs
  import pmcap_pkg::*;
#(
  parameter int unsigned   AW      = 8,
  parameter logic [AW-1:0] HDR_OFS = 8'h00,
  parameter logic [AW-1:0] CSR_OFS = 8'h04
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  input  logic          bus_we,
  input  logic [3:0]    bus_be,
  input  logic          bus_re,
  output logic [31:0]   bus_rdata,
  output logic          bus_rvalid,
  input  logic          pme_event,
  input  logic          irq_in,
  output logic          irq_out,
  output logic          pme_wake
);

  logic rst_sync_n;
  logic csr_wr;
  csr_t csr;

  pmcap_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign csr_wr = bus_we & (bus_addr == CSR_OFS);

  pmcap_csr u_csr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_sel    (csr_wr),
    .be        (bus_be),
    .wdata     (bus_wdata),
    .pme_event (pme_event),
    .csr       (csr)
  );

  pmcap_rdpath #(.AW(AW), .HDR_OFS(HDR_OFS), .CSR_OFS(CSR_OFS)) u_rd (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .re     (bus_re),
    .addr   (bus_addr),
    .csr    (csr),
    .rdata  (bus_rdata),
    .rvalid (bus_rvalid)
  );

  pmcap_gate u_gate (
    .csr      (csr),
    .irq_in   (irq_in),
    .irq_out  (irq_out),
    .pme_wake (pme_wake)
  );

endmodule

// File: rtl/pmcap_chk.sv
module pmcap_chk
  import pmcap_pkg::*;
#(
  parameter int unsigned   AW      = 8,
  parameter logic [AW-1:0] CSR_OFS = 8'h04
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic          bus_we,
  input logic [3:0]    bus_be,
  input logic          bus_re,
  input logic          bus_rvalid,
  input logic          pme_event,
  input logic          irq_out,
  input csr_t          csr
);

  logic csr_wr;
  assign csr_wr = bus_we && (bus_addr == CSR_OFS);

  a_r3_illegal_ps_dropped: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (csr_wr && bus_be[0] && (bus_wdata[1:0] == 2'b01 || bus_wdata[1:0] == 2'b10))
      |=> $stable(csr.ps));

  a_r3_ps_legal: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (csr.ps == PS_D0) || (csr.ps == PS_D3H));

  a_r4_event_sets: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pme_event |=> csr.wake_st);

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (csr_wr && bus_be[1] && bus_wdata[15] && !pme_event) |=> !csr.wake_st);

  a_r7_irq_blocked: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (csr.ps == PS_D3H) |-> !irq_out);

  a_r11_rvalid: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_re |=> bus_rvalid);

  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_re |=> !bus_rvalid);

  a_r12_lane1_masked: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (csr_wr && !bus_be[1] && !pme_event) |=> $stable(csr.wake_en) && $stable(csr.wake_st));

endmodule

bind pm_cap_regs pmcap_chk #(.AW(AW), .CSR_OFS(CSR_OFS)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_we     (bus_we),
  .bus_be     (bus_be),
  .bus_re     (bus_re),
  .bus_rvalid (bus_rvalid),
  .pme_event  (pme_event),
  .irq_out    (irq_out),
  .csr        (csr)
);

// File: tb/tb_pm_cap_regs.sv
`timescale 1ns/1ps
module tb_pm_cap_regs;

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic [3:0]  bus_be;
  logic        bus_re;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        pme_event;
  logic        irq_in;
  logic        irq_out;
  logic        pme_wake;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of the register state
  logic [1:0] m_ps;
  logic       m_en;
  logic       m_st;

  pm_cap_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_be(bus_be), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pme_event(pme_event), .irq_in(irq_in),
    .irq_out(irq_out), .pme_wake(pme_wake)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (a == 8'h00) return 32'h0000_0001;
    if (a == 8'h04) return {16'h0, m_st, 6'h0, m_en, 4'h0, 1'b1, 1'b0, m_ps};
    return 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one bus cycle, called at a negative edge
  task automatic step(input logic we, input logic re, input logic [7:0] a,
                      input logic [31:0] wd, input logic [3:0] be,
                      input logic ev, input logic irq, input string req);
    logic [31:0] er;
    bus_we = we; bus_re = re; bus_addr = a; bus_wdata = wd; bus_be = be;
    pme_event = ev; irq_in = irq;
    #1;
    chk("R7 irq gate", {31'h0, irq_out}, {31'h0, irq & (m_ps != 2'b11)});
    chk("R9 wake", {31'h0, pme_wake}, {31'h0, m_st & m_en});
    er = exp_read(a);
    @(posedge clk);
    if (we && a == 8'h04) begin
      if (be[0] && (wd[1:0] == 2'b00 || wd[1:0] == 2'b11)) m_ps = wd[1:0];
      if (be[1]) m_en = wd[8];
    end
    if (ev) m_st = 1'b1;
    else if (we && a == 8'h04 && be[1] && wd[15]) m_st = 1'b0;
    @(negedge clk);
    chk("R11 rvalid", {31'h0, bus_rvalid}, {31'h0, re});
    if (re) chk(req, bus_rdata, er);
    bus_we = 0; bus_re = 0; pme_event = 0;
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    step(0, 1, a, 32'h0, 4'h0, 0, 0, req);
  endtask

  task automatic wr(input logic [31:0] wd, input logic [3:0] be, input string req);
    step(1, 0, 8'h04, wd, be, 0, 0, req);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1357_9bdf));
    rst_n = 0; bus_addr = 0; bus_wdata = 0; bus_we = 0; bus_be = 0; bus_re = 0;
    pme_event = 0; irq_in = 0;
    m_ps = 2'b00; m_en = 0; m_st = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 wake after reset", {31'h0, pme_wake}, 32'h0);
    rd(8'h04, "R1 reset csr");
    chk("R1 reset value", exp_read(8'h04), 32'h0000_0008);
    // R2 header and write attempt
    rd(8'h00, "R2 header");
    step(1, 0, 8'h00, 32'hFFFF_FFFF, 4'hF, 0, 0, "R2 write");
    rd(8'h00, "R2 header after write");
    rd(8'h04, "R2 csr untouched");
    // R11 unmapped
    rd(8'h08, "R11 unmapped");
    rd(8'hFC, "R11 unmapped high");
    // R8 reserved bits
    wr(32'hFFFF_7EF4, 4'hF, "R8 reserved write");
    rd(8'h04, "R8 reserved read");
    // R3 legal / illegal codes
    wr(32'h0000_0003, 4'h1, "R3 to D3hot");
    rd(8'h04, "R3 D3hot");
    step(0, 0, 8'h04, 0, 0, 0, 1, "R7 irq in D3hot");
    wr(32'h0000_0001, 4'h1, "R3 01 from D3hot");
    rd(8'h04, "R3 01 dropped");
    wr(32'h0000_0002, 4'h1, "R3 10 from D3hot");
    rd(8'h04, "R3 10 dropped");
    // R6 enable, R4 set without enable, R10 context kept
    wr(32'h0000_0103, 4'h3, "R6 enable");
    step(0, 0, 8'h04, 0, 0, 1, 1, "R4 event");
    rd(8'h04, "R4 status set");
    wr(32'h0000_0000, 4'h1, "R10 to D0");
    rd(8'h04, "R10 context kept");
    wr(32'h0000_0002, 4'h1, "R3 10 from D0");
    rd(8'h04, "R3 D0 kept");
    // R12 lane masking
    wr(32'h0000_8003, 4'hD, "R12 lane1 masked");
    rd(8'h04, "R12 lane1 masked read");
    wr(32'h0000_0003, 4'hE, "R12 lane0 masked");
    rd(8'h04, "R12 lane0 masked read");
    // R5 write-0 no effect, set wins over clear, clear
    wr(32'h0000_0100, 4'h2, "R5 write 0");
    rd(8'h04, "R5 write 0 keeps");
    step(1, 0, 8'h04, 32'h0000_8100, 4'h2, 1, 0, "R5 collide");
    rd(8'h04, "R5 set wins");
    wr(32'h0000_8100, 4'h2, "R5 clear");
    rd(8'h04, "R5 cleared");
    // R4 set with enable off
    wr(32'h0000_0000, 4'h2, "R6 disable");
    step(0, 0, 8'h04, 0, 0, 1, 0, "R4 event no enable");
    rd(8'h04, "R4 status without enable");
    // R11 read with same-cycle write returns old value
    step(1, 1, 8'h04, 32'h0000_8103, 4'h3, 0, 1, "R11 read-old");
    rd(8'h04, "R11 after write");

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0]  a;
      logic [31:0] wd;
      int sel;
      sel = $urandom_range(0, 7);
      a = (sel < 5) ? 8'h04 : (sel == 5) ? 8'h00 : 8'($urandom_range(0, 63) * 4);
      wd = $urandom;
      step($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, a, wd,
           4'($urandom_range(0, 15)), $urandom_range(0, 5) == 0,
           $urandom_range(0, 1) == 1, "R3 R5 R12 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule